// File: doc/BRIEF.md
# Receive Packet Queue with Word Readout

This block sits on the receive side of a small Ethernet MAC. Frames arrive as a byte stream with a start-of-frame and an end-of-frame flag. Each accepted frame is stored in its own fixed-size slot as a record. The record holds a two-byte length field, then the frame bytes, then a CRC-32 computed over the frame. The slots form a ring with a read index and a stored-packet count.

Software empties the queue one 32-bit word at a time by reading a data register. The count drops only when the word that holds the last byte of a record has been read.

A small register set controls the block. Registers are selected by a 3-bit word index:
- status (0): bit 0 is receive-done, write 1 to clear.
- mask (1).
- control (2): bit 0 enables reception; writing bit 1 flushes the queue.
- data (3): reading it pops the next word.
- count (4): read only.

A read returns its value on `reg_rdata_o` in the cycle after `reg_rd_i`, and the value holds until the next read.

`SLOT_BYTES` sets the slot size. The default of 64 keeps the stored array small. A full-size build uses 2048.

Top module: `rx_packet_queue`

## Requirements
- R1: After reset:
  - the count reads 0, status reads 0, mask reads 1 and control reads 0;
  - `irq_o` is low;
  - a data read returns 0.
- R2: A frame whose start byte arrives while control bit 0 (enable) is clear is not stored, and the count is unchanged.
- R3: Record bytes 0 and 1 hold the frame size plus 6, low byte first. Frame bytes follow in order from record byte 2.
- R4: The four bytes after the frame are the CRC-32 of the frame bytes, least significant byte first. The CRC is reflected, uses polynomial 0x04C11DB7, is preset to all ones and is inverted at the end. For example, the 9-byte frame "123456789" gives the trailer 26 39 F4 CB.
- R5: Bytes in the record's final word beyond frame size plus 6 read as zero.
- R6: Each data read returns the next four record bytes, with the earliest byte in bits 7:0.
- R7: The count drops by one after the word that holds the last record byte is read. Records come out in arrival order, and the read index wraps modulo `NUM_SLOTS`.
- R8: A data read while the count is zero returns 0 and leaves the queue unchanged.
- R9: While `NUM_SLOTS` records are stored, a new frame is dropped and the count stays at `NUM_SLOTS`.
- R10: Writing control with bit 1 set does three things:
  - it sets the count to 0;
  - it discards any partly read record;
  - it aborts a frame being stored.
  The next stored frame is then read from its first word.
- R11: Storing a record sets status bit 0, and a status write with bit 0 set clears it. `irq_o` is high exactly when status bit 0 and mask bit 0 are both set.
- R12: A frame longer than `SLOT_BYTES` minus 6 bytes is dropped whole, and the count is unchanged.
- R13: The block stays busy for five cycles after an end-of-frame byte while it writes the trailer and the header. A frame whose start byte arrives in that window is lost, and its remaining bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_data_i | input | 8 | Receive byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after the read |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is a full ring whose read index is not at slot zero, so that the drop on the thirty-second frame and the later drain both cross the wrap point. The bench first sweeps every legal frame size from 1 to the slot limit. Each frame is stored and read back completely, which leaves the read index past the wrap. Only then does the bench fill all slots with frames of varied length, offer one more frame, and drain the ring in order. A flush issued in the middle of a partly read record is reached by reading only the first two words of a record before writing the control register.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    WR_IDLE,
    WR_FRAME,
    WR_DROP,
    WR_CRC,
    WR_HDR
  } wr_state_e;

  localparam logic [2:0] REG_STAT  = 3'd0;
  localparam logic [2:0] REG_MASK  = 3'd1;
  localparam logic [2:0] REG_CTRL  = 3'd2;
  localparam logic [2:0] REG_DATA  = 3'd3;
  localparam logic [2:0] REG_COUNT = 3'd4;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FLUSH_BIT = 1;

  // reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crc32_next(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 496,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  for (genvar g = 0; g < 4; g++) begin : lane_g
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[waddr_i] <= wdata_i[8*g +: 8];
    end
    assign rdata_o[8*g +: 8] = mem[raddr_i];
  end
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
  import rxq_pkg::*;
#(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 64,
  localparam int OFF_W  = $clog2(SLOT_BYTES) + 1,
  localparam int WORD_W = $clog2(SLOT_BYTES / 4),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int AW     = SLOT_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic [SLOT_W-1:0] rd_idx_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  output logic              commit_o
);
  localparam logic [OFF_W-1:0] OFF_FIRST  = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_SECOND = OFF_W'(3);
  localparam logic [OFF_W-1:0] OFF_LIMIT  = OFF_W'(SLOT_BYTES - 4);
  localparam logic [OFF_W-1:0] OFF_ONE    = OFF_W'(1);

  wr_state_e         state_q, state_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [31:0]       crc_q, crc_d;
  logic [1:0]        tcnt_q, tcnt_d;

  logic [SLOT_W:0]   slot_sum;
  logic [SLOT_W-1:0] start_slot;
  logic              start_ok;
  logic              wr_byte, hdr_we;
  logic [7:0]        byte_val;
  logic [OFF_W-1:0]  byte_off;
  logic [SLOT_W-1:0] byte_slot;
  logic [31:0]       crc_fin;
  logic [1:0]        lane;

  always_comb begin
    slot_sum = {1'b0, rd_idx_i} + (SLOT_W + 1)'(count_i);
    if (slot_sum >= (SLOT_W + 1)'(NUM_SLOTS)) start_slot = SLOT_W'(slot_sum - (SLOT_W + 1)'(NUM_SLOTS));
    else                                      start_slot = slot_sum[SLOT_W-1:0];
  end

  assign start_ok = en_i && (count_i < CNT_W'(NUM_SLOTS));
  assign crc_fin  = ~crc_q;

  always_comb begin
    state_d   = state_q;
    off_d     = off_q;
    slot_d    = slot_q;
    crc_d     = crc_q;
    tcnt_d    = tcnt_q;
    wr_byte   = 1'b0;
    hdr_we    = 1'b0;
    commit_o  = 1'b0;
    byte_val  = rx_data_i;
    byte_off  = off_q;
    byte_slot = slot_q;
    if (flush_i) begin
      state_d = WR_IDLE;
    end else begin
      unique case (state_q)
        WR_IDLE: begin
          if (rx_valid_i && rx_sof_i && start_ok) begin
            wr_byte   = 1'b1;
            byte_off  = OFF_FIRST;
            byte_slot = start_slot;
            slot_d    = start_slot;
            crc_d     = crc32_next(32'hFFFF_FFFF, rx_data_i);
            off_d     = OFF_SECOND;
            tcnt_d    = 2'd0;
            state_d   = rx_eof_i ? WR_CRC : WR_FRAME;
          end
        end
        WR_FRAME: begin
          if (rx_valid_i) begin
            if (off_q == OFF_LIMIT) begin
              state_d = rx_eof_i ? WR_IDLE : WR_DROP;
            end else begin
              wr_byte = 1'b1;
              crc_d   = crc32_next(crc_q, rx_data_i);
              off_d   = off_q + OFF_ONE;
              if (rx_eof_i) state_d = WR_CRC;
            end
          end
        end
        WR_DROP: begin
          if (rx_valid_i && rx_eof_i) state_d = WR_IDLE;
        end
        WR_CRC: begin
          wr_byte  = 1'b1;
          byte_val = crc_fin[{tcnt_q, 3'b000} +: 8];
          off_d    = off_q + OFF_ONE;
          tcnt_d   = tcnt_q + 2'd1;
          if (tcnt_q == 2'd3) state_d = WR_HDR;
        end
        WR_HDR: begin
          hdr_we   = 1'b1;
          commit_o = 1'b1;
          state_d  = WR_IDLE;
        end
        default: state_d = WR_IDLE;
      endcase
    end
  end

  // lane 0 writes clear the whole word, so tail padding is zero
  assign lane = byte_off[1:0];
  always_comb begin
    mem_we_o = wr_byte | hdr_we;
    if (hdr_we) begin
      mem_addr_o  = {slot_q, WORD_W'(0)};
      mem_be_o    = 4'b0011;
      mem_wdata_o = {16'h0, 16'(off_q)};
    end else begin
      mem_addr_o  = {byte_slot, byte_off[WORD_W+1:2]};
      mem_be_o    = (lane == 2'd0) ? 4'b1111 : (4'b0001 << lane);
      mem_wdata_o = {24'h0, byte_val} << {lane, 3'b000};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      off_q   <= '0;
      slot_q  <= '0;
      crc_q   <= '1;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      slot_q  <= slot_d;
      crc_q   <= crc_d;
      tcnt_q  <= tcnt_d;
    end
  end
endmodule

// File: rtl/rxq_drain.sv
module rxq_drain #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 64,
  localparam int WORD_W = $clog2(SLOT_BYTES / 4),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int AW     = SLOT_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              commit_i,
  input  logic              pop_req_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [AW-1:0]     mem_raddr_o,
  output logic [SLOT_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [31:0]       word_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] rd_idx_q;
  logic [CNT_W-1:0]  count_q;
  logic [WORD_W-1:0] rword_q;
  logic [15:0]       rlen_q;
  logic [15:0]       len_cur, consumed;
  logic              has_rec, pop, last, done;

  // length comes from the header word while it is being read
  assign len_cur  = (rword_q == '0) ? mem_rdata_i[15:0] : rlen_q;
  assign consumed = 16'({rword_q, 2'b00}) + 16'd4;
  assign last     = consumed >= len_cur;
  assign has_rec  = count_q != '0;
  assign pop      = pop_req_i && has_rec && !flush_i;
  assign done     = pop && last;

  assign mem_raddr_o = {rd_idx_q, rword_q};
  assign rd_idx_o    = rd_idx_q;
  assign count_o     = count_q;
  assign word_o      = has_rec ? mem_rdata_i : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      count_q  <= '0;
      rword_q  <= '0;
      rlen_q   <= '0;
    end else if (flush_i) begin
      count_q <= '0;
      rword_q <= '0;
    end else begin
      if (pop) begin
        if (rword_q == '0) rlen_q <= mem_rdata_i[15:0];
        if (last) begin
          rword_q  <= '0;
          rd_idx_q <= (rd_idx_q == LAST_SLOT) ? '0 : rd_idx_q + SLOT_W'(1);
        end else begin
          rword_q <= rword_q + WORD_W'(1);
        end
      end
      unique case ({commit_i, done})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_packet_queue.sv
module rx_packet_queue
  import rxq_pkg::*;
#(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 64,
  localparam int WORD_W = $clog2(SLOT_BYTES / 4),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int AW     = SLOT_W + WORD_W,
  localparam int DEPTH  = NUM_SLOTS * (SLOT_BYTES / 4)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic [7:0]  rx_data_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic              en_q, mask_q, stat_q;
  logic [31:0]       rdata_q;
  logic              flush, commit, pop_req;
  logic [SLOT_W-1:0] rd_idx;
  logic [CNT_W-1:0]  count;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata, mem_rdata, word;

  assign flush   = reg_wr_i && (reg_addr_i == REG_CTRL) && reg_wdata_i[CTRL_FLUSH_BIT];
  assign pop_req = reg_rd_i && (reg_addr_i == REG_DATA);

  rxq_writer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .flush_i    (flush),
    .rx_valid_i (rx_valid_i),
    .rx_sof_i   (rx_sof_i),
    .rx_eof_i   (rx_eof_i),
    .rx_data_i  (rx_data_i),
    .rd_idx_i   (rd_idx),
    .count_i    (count),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_waddr),
    .mem_be_o   (mem_be),
    .mem_wdata_o(mem_wdata),
    .commit_o   (commit)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .be_i   (mem_be),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  rxq_drain #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .commit_i   (commit),
    .pop_req_i  (pop_req),
    .mem_rdata_i(mem_rdata),
    .mem_raddr_o(mem_raddr),
    .rd_idx_o   (rd_idx),
    .count_o    (count),
    .word_o     (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mask_q  <= 1'b1;
      stat_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == REG_CTRL) en_q   <= reg_wdata_i[CTRL_EN_BIT];
      if (reg_wr_i && reg_addr_i == REG_MASK) mask_q <= reg_wdata_i[0];
      if (commit)                                                   stat_q <= 1'b1;
      else if (reg_wr_i && reg_addr_i == REG_STAT && reg_wdata_i[0]) stat_q <= 1'b0;
      if (reg_rd_i) begin
        unique case (reg_addr_i)
          REG_STAT:  rdata_q <= {31'h0, stat_q};
          REG_MASK:  rdata_q <= {31'h0, mask_q};
          REG_CTRL:  rdata_q <= {31'h0, en_q};
          REG_DATA:  rdata_q <= word;
          REG_COUNT: rdata_q <= 32'(count);
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = stat_q & mask_q;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
#(
  parameter int NUM_SLOTS = 31,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_rdata_o,
  input logic [CNT_W-1:0] count,
  input logic             commit,
  input logic             flush,
  input logic             mask
);
  a_r9_commit_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (int'(count) < NUM_SLOTS));

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count) <= NUM_SLOTS);

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count == '0));

  a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush |=> ((int'(count) - int'($past(count)) <= 1) && (int'($past(count)) - int'(count) <= 1)));

  a_r11_irq_on_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && mask && !(reg_wr_i && reg_addr_i == REG_MASK)) |=> irq_o);

  a_r8_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == REG_DATA && count == '0) |=> (reg_rdata_o == 32'h0));
endmodule

bind rx_packet_queue rxq_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .count      (count),
  .commit     (commit),
  .flush      (flush),
  .mask       (mask_q)
);

// File: tb/tb_rx_packet_queue.sv
`timescale 1ns/1ps
module tb_rx_packet_queue;
  localparam int NS   = 31;
  localparam int SB   = 64;
  localparam int MAXF = SB - 6;
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_CTRL = 3'd2, A_DATA = 3'd3, A_COUNT = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = 8'h0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] fb [SB+8];

  always #2.5 clk = ~clk;

  rx_packet_queue #(.NUM_SLOTS(NS), .SLOT_BYTES(SB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_data_i(rx_data),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) fb[i] = 8'(seed * 7 + i * 13 + 1);
  endtask

  task automatic send_frame(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = fb[i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // non-reflected shift form, output bit-reversed
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c, r;
    logic fbk;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        fbk = c[31] ^ fb[i][k];
        c = {c[30:0], 1'b0};
        if (fbk) c = c ^ 32'h04C1_1DB7;
      end
    end
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return ~r;
  endfunction

  function automatic logic [7:0] rec_byte(input int n, input int j, input logic [31:0] c);
    int tot;
    tot = n + 6;
    if (j == 0) return 8'(tot);
    if (j == 1) return 8'(tot >> 8);
    if (j < n + 2) return fb[j-2];
    if (j < n + 6) return 8'(c >> (8 * (j - n - 2)));
    return 8'h00;
  endfunction

  task automatic read_record(input int n);
    logic [31:0] c, v, e;
    int nw;
    c  = ref_crc(n);
    nw = (n + 9) / 4;
    for (int w = 0; w < nw; w++) begin
      reg_read(A_DATA, v);
      e = {rec_byte(n, 4*w+3, c), rec_byte(n, 4*w+2, c), rec_byte(n, 4*w+1, c), rec_byte(n, 4*w, c)};
      if (w == 0)       chk("R3 R6 header word", v, e);
      else if (w == nw - 1) chk("R4 R5 R6 last word", v, e);
      else              chk("R4 R6 body word", v, e);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lens [NS];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    reg_read(A_COUNT, v); chk("R1 count", v, 0);
    reg_read(A_STAT, v);  chk("R1 status", v, 0);
    reg_read(A_MASK, v);  chk("R1 mask", v, 1);
    reg_read(A_CTRL, v);  chk("R1 control", v, 0);
    reg_read(A_DATA, v);  chk("R1 data", v, 0);

    // R2 disabled
    fill(12, 1); send_frame(12, 8);
    reg_read(A_COUNT, v); chk("R2 count disabled", v, 0);
    reg_write(A_CTRL, 32'h1);

    // R4 known vector
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    send_frame(9, 8);
    chk("R11 irq after store", {31'h0, irq}, 32'h1);
    reg_read(A_COUNT, v); chk("R7 count one", v, 1);
    reg_read(A_DATA, v); chk("R3 known header", v, 32'h3231_000F);
    reg_read(A_DATA, v); chk("R6 known body", v, 32'h3635_3433);
    reg_read(A_DATA, v); chk("R4 known crc lo", v, 32'h2639_3837);
    reg_read(A_DATA, v); chk("R4 R5 known crc hi", v, 32'h00CB_F439);
    reg_read(A_COUNT, v); chk("R7 count zero", v, 0);

    // R11 status and mask
    reg_write(A_MASK, 32'h0);
    chk("R11 masked irq", {31'h0, irq}, 32'h0);
    reg_read(A_STAT, v); chk("R11 status set", v, 1);
    reg_write(A_STAT, 32'h1);
    reg_read(A_STAT, v); chk("R11 status cleared", v, 0);
    reg_write(A_MASK, 32'h1);
    chk("R11 irq low after clear", {31'h0, irq}, 32'h0);

    // R3-R7 sweep of every legal size; read index wraps
    for (int n = 1; n <= MAXF; n++) begin
      fill(n, n); send_frame(n, 7);
      reg_read(A_COUNT, v); chk("R7 count after store", v, 1);
      read_record(n);
      reg_read(A_COUNT, v); chk("R7 count after drain", v, 0);
    end

    // R12 oversize
    fill(MAXF + 1, 50); send_frame(MAXF + 1, 8);
    reg_read(A_COUNT, v); chk("R12 oversize dropped", v, 0);
    fill(MAXF + 5, 51); send_frame(MAXF + 5, 8);
    reg_read(A_COUNT, v); chk("R12 oversize dropped long", v, 0);
    fill(MAXF, 52); send_frame(MAXF, 8);
    read_record(MAXF);

    // R9 full ring, then R7 ordered drain
    for (int k = 0; k < NS; k++) begin
      lens[k] = 1 + (k * 5) % MAXF;
      fill(lens[k], 100 + k); send_frame(lens[k], 7);
    end
    reg_read(A_COUNT, v); chk("R9 full count", v, NS);
    fill(8, 999); send_frame(8, 8);
    reg_read(A_COUNT, v); chk("R9 count stays full", v, NS);
    for (int k = 0; k < NS; k++) begin
      fill(lens[k], 100 + k);
      read_record(lens[k]);
    end
    reg_read(A_COUNT, v); chk("R7 ring drained", v, 0);

    // R8 empty read
    reg_read(A_DATA, v); chk("R8 empty read", v, 0);
    reg_read(A_COUNT, v); chk("R8 count unchanged", v, 0);
    fill(6, 7); send_frame(6, 8);
    read_record(6);

    // R10 flush mid-record
    fill(10, 3); send_frame(10, 8);
    fill(12, 4); send_frame(12, 8);
    reg_read(A_DATA, v);
    reg_read(A_DATA, v);
    reg_write(A_CTRL, 32'h3);
    reg_read(A_COUNT, v); chk("R10 count flushed", v, 0);
    reg_read(A_DATA, v); chk("R10 data empty", v, 0);
    fill(9, 5); send_frame(9, 8);
    read_record(9);
    reg_read(A_COUNT, v); chk("R10 count after new", v, 0);

    // R13 start during trailer window is lost
    fill(14, 20); send_frame(14, 0);
    fill(20, 21); send_frame(20, 8);
    reg_read(A_COUNT, v); chk("R13 second frame lost", v, 1);
    fill(14, 20); read_record(14);
    reg_read(A_COUNT, v); chk("R13 count zero", v, 0);

    summary();
    $finish;
  end
endmodule